// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block derives two banks of slower clocks from one fast input clock. Bank A runs at one half or one quarter of the input rate. Bank B runs at one quarter or one sixth of it. Each bank has its own ratio select. Every divided output has a 50% duty cycle, and each bank drives two output copies that are always identical.

A stop request input freezes every output at its present level. It is sampled on the falling edge of the input clock, so a stop or a restart takes effect on a whole input cycle and never cuts an output level short. An active-high master reset clears all dividers at once and forces every output low. When the reset is released, all outputs start together.

A ratio change waits for the next transition of its bank, so the half-period already under way finishes at the old length. The model is fully synchronous to the input clock. Only the master reset acts asynchronously.

Top module: `clkdiv_dual_bank`

## Requirements
- R1: With `a_sel` = 0 the bank A outputs toggle on every advancing rising edge (input divided by 2). With `a_sel` = 1 they toggle on every second advancing edge (divided by 4).
- R2: With `b_sel` = 0 the bank B outputs toggle on every second advancing rising edge (divided by 4). With `b_sel` = 1 they toggle on every third advancing edge (divided by 6).
- R3: While `mrst` is 1, every output is 0 and all divider state is cleared. This takes effect at once, without waiting for a clock edge.
- R4: While the captured stop request is 1, every output keeps its level and no divider advances.
- R5: `freeze_req` is captured on the falling edge of `clk`. The captured value decides whether the following rising edge advances the dividers. A value of 0, which is also the level used when the pin is tied off, means run.
- R6: A change of a bank's select takes effect only at that bank's next output transition. The level in progress keeps the length set by the old ratio.
- R7: On the first advancing rising edge after `mrst` falls, every output rises from 0 to 1 on that same edge.
- R8: The two copies of a bank's output are equal on every cycle.
- R9: Outside reset, a bank B output never changes on two consecutive rising edges, whatever the select or stop activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| mrst | input | 1 | Master reset, active high, asynchronous |
| freeze_req | input | 1 | Stop request; 1 freezes the outputs, 0 lets them run |
| a_sel | input | 1 | Bank A ratio: 0 gives divide by 2, 1 gives divide by 4 |
| b_sel | input | 1 | Bank B ratio: 0 gives divide by 4, 1 gives divide by 6 |
| a_out | output | COPIES | Bank A divided clock copies |
| b_out | output | COPIES | Bank B divided clock copies |

## Verification
Some properties are checked on every cycle:
- all outputs are low while reset is held;
- the copies of each bank agree;
- nothing moves while the captured stop is active;
- bank B never changes on two edges in a row.

The actual ratios, the way a mid-level select change is deferred, the one-cycle delay of the falling-edge stop capture, and the common first rise after reset depend on history over several cycles. Only the bench's reference model shows these, by comparison in scenarios that flip selects, stops and resets at awkward moments.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   // Counter width able to hold 0 .. max_half-1
   function automatic int unsigned cnt_width(input int unsigned max_half);
      return (max_half < 2) ? 1 : $clog2(max_half);
   endfunction

   function automatic int unsigned max2(input int unsigned x, input int unsigned y);
      return (x > y) ? x : y;
   endfunction

   typedef enum logic {
      RATIO_LO = 1'b0,
      RATIO_HI = 1'b1
   } ratio_sel_e;

endpackage

// File: rtl/clkdiv_run_sync.sv
module clkdiv_run_sync (
   input  logic clk,
   input  logic mrst,
   input  logic freeze_req,
   output logic run
);
   logic run_q;

   // Falling-edge capture: the value is settled half a cycle before the
   // rising edge it gates, so a stop or restart always spans whole cycles.
   always_ff @(negedge clk or posedge mrst) begin
      if (mrst) run_q <= 1'b1;
      else      run_q <= ~freeze_req;
   end

   assign run = run_q;
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
   import clkdiv_pkg::*;
#(
   parameter int unsigned HALF_LO    = 1,
   parameter int unsigned HALF_HI    = 2,
   parameter int unsigned COPIES     = 2,
   parameter bit          REG_COPIES = 1'b1
) (
   input  logic              clk,
   input  logic              mrst,
   input  logic              run,
   input  logic              sel,
   output logic [COPIES-1:0] out
);
   localparam int unsigned CW = cnt_width(max2(HALF_LO, HALF_HI));
   localparam logic [CW-1:0] LO_M1 = CW'(HALF_LO - 1);
   localparam logic [CW-1:0] HI_M1 = CW'(HALF_HI - 1);

   if (HALF_LO < 1) begin : g_bad_lo
      $error("clkdiv_bank: HALF_LO must be at least 1");
   end
   if (HALF_HI < 1) begin : g_bad_hi
      $error("clkdiv_bank: HALF_HI must be at least 1");
   end
   if (COPIES < 1) begin : g_bad_copies
      $error("clkdiv_bank: COPIES must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] span_q;
   logic [CW-1:0] live_span;
   logic [CW-1:0] cur_span;
   logic          at_start;
   logic          lvl_q;

   assign live_span = (ratio_sel_e'(sel) == RATIO_HI) ? HI_M1 : LO_M1;
   assign at_start  = (cnt_q == '0);
   // The ratio is read only when a level begins; afterwards the held copy rules.
   assign cur_span  = at_start ? live_span : span_q;

   always_ff @(posedge clk or posedge mrst) begin
      if (mrst) begin
         cnt_q  <= '0;
         span_q <= '0;
         lvl_q  <= 1'b0;
      end else if (run) begin
         if (at_start) begin
            lvl_q  <= ~lvl_q;
            span_q <= live_span;
         end
         cnt_q <= (cnt_q == cur_span) ? '0 : cnt_q + 1'b1;
      end
   end

   for (genvar i = 0; i < COPIES; i++) begin : g_copy
      if (REG_COPIES) begin : g_reg
         logic copy_q;
         always_ff @(posedge clk or posedge mrst) begin
            if (mrst)                 copy_q <= 1'b0;
            else if (run && at_start) copy_q <= ~copy_q;
         end
         assign out[i] = copy_q;
      end else begin : g_wire
         assign out[i] = lvl_q;
      end
   end
endmodule

// File: rtl/clkdiv_dual_bank.sv
module clkdiv_dual_bank #(
   parameter int unsigned A_HALF_LO  = 1,
   parameter int unsigned A_HALF_HI  = 2,
   parameter int unsigned B_HALF_LO  = 2,
   parameter int unsigned B_HALF_HI  = 3,
   parameter int unsigned COPIES     = 2,
   parameter bit          REG_COPIES = 1'b1
) (
   input  logic              clk,
   input  logic              mrst,
   input  logic              freeze_req,
   input  logic              a_sel,
   input  logic              b_sel,
   output logic [COPIES-1:0] a_out,
   output logic [COPIES-1:0] b_out
);
   logic run_w;

   clkdiv_run_sync u_run (
      .clk        (clk),
      .mrst       (mrst),
      .freeze_req (freeze_req),
      .run        (run_w)
   );

   clkdiv_bank #(
      .HALF_LO    (A_HALF_LO),
      .HALF_HI    (A_HALF_HI),
      .COPIES     (COPIES),
      .REG_COPIES (REG_COPIES)
   ) u_bank_a (
      .clk  (clk),
      .mrst (mrst),
      .run  (run_w),
      .sel  (a_sel),
      .out  (a_out)
   );

   clkdiv_bank #(
      .HALF_LO    (B_HALF_LO),
      .HALF_HI    (B_HALF_HI),
      .COPIES     (COPIES),
      .REG_COPIES (REG_COPIES)
   ) u_bank_b (
      .clk  (clk),
      .mrst (mrst),
      .run  (run_w),
      .sel  (b_sel),
      .out  (b_out)
   );
endmodule

// File: rtl/clkdiv_dual_bank_chk.sv
module clkdiv_dual_bank_chk #(
   parameter int unsigned COPIES     = 2,
   parameter bit          B_MIN_TWO  = 1'b1
) (
   input logic              clk,
   input logic              mrst,
   input logic              run,
   input logic [COPIES-1:0] a_out,
   input logic [COPIES-1:0] b_out
);
   a_r3_reset_low: assert property (@(posedge clk)
      mrst |-> (a_out == '0 && b_out == '0))
      else $error("R3: output high during master reset");

   a_r8_copies_match: assert property (@(posedge clk) disable iff (mrst)
      (a_out == {COPIES{a_out[0]}}) && (b_out == {COPIES{b_out[0]}}))
      else $error("R8: output copies differ");

   a_r4_freeze_hold: assert property (@(posedge clk) disable iff (mrst)
      !run |=> ($stable(a_out) && $stable(b_out)))
      else $error("R4: output moved while stopped");

   if (B_MIN_TWO) begin : g_bmin
      a_r9_b_min_level: assert property (@(posedge clk) disable iff (mrst)
         (b_out[0] != $past(b_out[0])) |=> $stable(b_out[0]))
         else $error("R9: bank B changed on consecutive edges");
   end
endmodule

bind clkdiv_dual_bank clkdiv_dual_bank_chk #(
   .COPIES    (COPIES),
   .B_MIN_TWO ((B_HALF_LO > 1) && (B_HALF_HI > 1))
) u_chk (
   .clk   (clk),
   .mrst  (mrst),
   .run   (run_w),
   .a_out (a_out),
   .b_out (b_out)
);

// File: tb/clkdiv_dual_bank_bench.sv
`timescale 1ns/1ps
module clkdiv_dual_bank_bench;
   localparam int COPIES = 2;

   logic clk = 1'b0;
   logic mrst = 1'b1;
   logic freeze_req = 1'b0;
   logic a_sel = 1'b0;
   logic b_sel = 1'b0;
   logic [COPIES-1:0] a_out;
   logic [COPIES-1:0] b_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   string tag = "R3";

   always #4 clk = ~clk;

   clkdiv_dual_bank u_clkdiv_dual_bank (
      .clk        (clk),
      .mrst       (mrst),
      .freeze_req (freeze_req),
      .a_sel      (a_sel),
      .b_sel      (b_sel),
      .a_out      (a_out),
      .b_out      (b_out)
   );

   // Behavioural reference: remaining cycles before the next flip.
   bit m_run = 1'b1;
   bit m_a = 1'b0, m_b = 1'b0;
   int m_a_left = 0, m_b_left = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!mrst && m_run) begin
         if (m_a_left == 0) begin
            m_a = !m_a;
            m_a_left = a_sel ? 1 : 0;   // R1: half-period 2 or 1
         end else m_a_left--;
         if (m_b_left == 0) begin
            m_b = !m_b;
            m_b_left = b_sel ? 2 : 1;   // R2: half-period 3 or 2
         end else m_b_left--;
      end
   end

   always @(negedge clk) begin
      if (mrst) begin
         m_a = 0; m_b = 0; m_a_left = 0; m_b_left = 0;
      end
      if (!done) begin
         check(a_out == {COPIES{m_a}}, {tag, " bank A (R8 copies)"}, a_out, {COPIES{m_a}});
         check(b_out == {COPIES{m_b}}, {tag, " bank B (R8 copies)"}, b_out, {COPIES{m_b}});
      end
      m_run = mrst ? 1'b1 : !freeze_req;   // R5 falling-edge capture
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   initial begin
      logic [COPIES-1:0] ha, hb;
      int run_len, min_len;
      bit prev;
      // R3 reset state
      cyc(3);
      check(a_out == '0 && b_out == '0, "R3 reset low", {a_out, b_out}, 0);
      tag = "R7";
      mrst = 1'b0;
      @(posedge clk); #1;
      check(a_out == '1 && b_out == '1, "R7 common first rise", {a_out, b_out}, 15);
      #1;
      tag = "R1/R2 default";
      cyc(24);
      tag = "R1 sel A hi"; a_sel = 1'b1; cyc(20);
      tag = "R2 sel B hi"; b_sel = 1'b1; cyc(30);
      tag = "R6 mid-level change"; b_sel = 1'b0; cyc(1); a_sel = 1'b0; cyc(5);
      b_sel = 1'b1; cyc(2); b_sel = 1'b0; cyc(1); b_sel = 1'b1; cyc(13);
      // R4 freeze hold
      tag = "R4 freeze"; freeze_req = 1'b1;
      cyc(1); ha = a_out; hb = b_out;
      cyc(7);
      check(a_out == ha && b_out == hb, "R4 hold", {a_out, b_out}, {ha, hb});
      tag = "R5 restart"; freeze_req = 1'b0; cyc(9);
      tag = "R5 stop pulses";
      for (int i = 0; i < 12; i++) begin
         freeze_req = i[0]; cyc(1 + (i % 3));
      end
      freeze_req = 1'b0;
      tag = "R3 mid-run reset"; cyc(2); mrst = 1'b1; #1;
      check(a_out == '0 && b_out == '0, "R3 async clear", {a_out, b_out}, 0);
      #1; cyc(3);
      tag = "R7 second release"; a_sel = 1'b1; b_sel = 1'b1; mrst = 1'b0;
      @(posedge clk); #1;
      check(a_out == '1 && b_out == '1, "R7 common rise", {a_out, b_out}, 15);
      #1;
      // R9 minimum bank B level under select and stop churn
      tag = "R9 churn"; min_len = 1000; run_len = 0; prev = b_out[0];
      for (int i = 0; i < 60; i++) begin
         b_sel = (i % 5) < 2; freeze_req = (i % 7) == 3;
         @(negedge clk);
         if (b_out[0] == prev) run_len++;
         else begin
            if (run_len + 1 < min_len) min_len = run_len + 1;
            run_len = 0; prev = b_out[0];
         end
         @(posedge clk); #2;
      end
      freeze_req = 1'b0;
      check(min_len >= 2, "R9 min level", min_len, 2);
      cyc(4);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule